// File: doc/BRIEF.md
# Hierarchical SMI Status Aggregator

This block gathers the causes of a system-management interrupt into two levels of status and raises one SMI request line while any cause is pending. The top-level status word holds two kinds of bits. Two bits latch their own events: a software request and an A20 gate toggle. Reading the top-level word clears those two. Four more bits are live summaries of pending status kept in other sources' own second-level registers: LPC, ACPI, audio and power management. Reading the top-level word does not change them. A last summary bit reflects the local traps register.

The traps register is the second level for general traps, the user-defined device 3 trap and the function-space configuration traps. It can be read in two ways. The mirror address returns its value and changes nothing. The clearing address returns its value and then empties it. Each trap input is captured only when its own enable is set, so a disabled trap neither reports nor raises the SMI. Reads use a single-cycle strobe with a two-bit address, and the read data is registered.

Top module: `smi_status_agg`

## Requirements
- R1: After reset, rdata_o is 0000h, smi_o is 0 and every latched status bit is clear.
- R2: A pulse on sw_smi_i sets top-level bit 8. A read of address 0 (top level) returns the bit and then clears it.
- R3: Top-level bit 7 is set by a20_gate_wr_i or a20_kbd_cmd_i only while a20_en_i is 1. A read of address 0 clears it.
- R4: Top-level bits 3, 2, 1 and 0 follow lpc_pend_i, acpi_pend_i, audio_pend_i and pme_pend_i in that order. A top-level read does not clear them.
- R5: Top-level bit 9 is set whenever any bit of the traps register is set, and it drops in the same cycle the register becomes empty.
- R6: Top-level bits 15:10 and 6:4 read as 0. Traps register bits 15:6 read as 0.
- R7: A read of address 1 (mirror) returns the traps register and leaves it unchanged.
- R8: Traps register bits 3:0 capture gen_trap_i wherever gen_trap_en_i is set. Bit 4 captures udd3_trap_i when udd3_en_i is set. Bit 5 captures any function-space trap whose bit in func_trap_en_i is set.
- R9: A read of address 2 (clearing) returns the traps register and then clears it.
- R10: An event that arrives in the same cycle as a read that clears its bit leaves that bit set.
- R11: smi_o is 1 exactly while the top-level value is nonzero.
- R12: Read data appears on rdata_o in the cycle after rd_en_i and holds until the next read. Address 3 reads 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 2 | Read address: 0 top level, 1 mirror, 2 clearing traps, 3 unused |
| rdata_o | output | 16 | Registered read data |
| smi_o | output | 1 | SMI request, high while any top-level bit is set |
| sw_smi_i | input | 1 | Software SMI request pulse |
| a20_gate_wr_i | input | 1 | Write to the A20 gate register |
| a20_kbd_cmd_i | input | 1 | Keyboard command that toggles A20 |
| a20_en_i | input | 1 | Enable for A20 toggle capture |
| lpc_pend_i | input | 1 | LPC second-level status pending |
| acpi_pend_i | input | 1 | ACPI second-level status pending |
| audio_pend_i | input | 1 | Audio second-level status pending |
| pme_pend_i | input | 1 | Power-management second-level status pending |
| gen_trap_i | input | 4 | General trap and timer events |
| gen_trap_en_i | input | 4 | Per-bit enables for gen_trap_i |
| func_trap_i | input | 5 | Trapped configuration accesses, one per function-space class |
| func_trap_en_i | input | 5 | Per-class enables for func_trap_i |
| udd3_trap_i | input | 1 | Trapped access to user-defined device 3 |
| udd3_en_i | input | 1 | Enable for udd3_trap_i |

## Verification
On every cycle, the assertions check several properties. An event always leaves its bit set one cycle later, even when a clearing read arrives in the same cycle. A clearing read with no new event empties the register. A mirror read never drops a bit. A latched cause always drives smi_o. The reserved bits of a read are zero. The bench's scenarios cover the rest. These are the enable gating of each trap class and the A20 cause, the summary bits staying up across top-level reads, bit 9 following the traps register to zero, and read data holding between reads.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
  localparam int unsigned DATA_W = 16;
  localparam logic [1:0] ADDR_TOP    = 2'd0;
  localparam logic [1:0] ADDR_MIRROR = 2'd1;
  localparam logic [1:0] ADDR_CLEAR  = 2'd2;
  localparam int unsigned BIT_TRAPS = 9;
  localparam int unsigned BIT_SW    = 8;
  localparam int unsigned BIT_A20   = 7;
  localparam int unsigned BIT_LPC   = 3;
  localparam int unsigned BIT_ACPI  = 2;
  localparam int unsigned BIT_AUDIO = 1;
  localparam int unsigned BIT_PME   = 0;
endpackage

// File: rtl/smi_rc_bits.sv
module smi_rc_bits #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q, sts_d;

  always_comb begin
    sts_d = (clr_i ? '0 : sts_q) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> sts_o[i]); // R10
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[i]) |=> !sts_o[i]); // R2
  end
endmodule

// File: rtl/smi_trap_status.sv
module smi_trap_status #(
  parameter int unsigned NUM_GEN  = 4,
  parameter int unsigned NUM_FUNC = 5,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GEN-1:0]  gen_hit_i,
  input  logic [NUM_GEN-1:0]  gen_en_i,
  input  logic [NUM_FUNC-1:0] func_hit_i,
  input  logic [NUM_FUNC-1:0] func_en_i,
  input  logic                udd_hit_i,
  input  logic                udd_en_i,
  input  logic                clr_i,
  output logic [DATA_W-1:0]   sts_o
);
  localparam int unsigned UDD_POS  = NUM_GEN;
  localparam int unsigned FUNC_POS = NUM_GEN + 1;
  localparam int unsigned USED_W   = NUM_GEN + 2;

  logic [USED_W-1:0] new_evt;
  logic [USED_W-1:0] sts_q;

  always_comb begin
    new_evt                  = '0;
    new_evt[NUM_GEN-1:0]     = gen_hit_i & gen_en_i;
    new_evt[UDD_POS]         = udd_hit_i & udd_en_i;
    new_evt[FUNC_POS]        = |(func_hit_i & func_en_i);
  end

  smi_rc_bits #(.N(USED_W)) u_bits (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (new_evt),
    .clr_i (clr_i),
    .sts_o (sts_q)
  );

  always_comb begin
    sts_o               = '0;
    sts_o[USED_W-1:0]   = sts_q;
  end

  AST_CLEAR_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && new_evt == '0) |=> (sts_o == '0)); // R9
endmodule

// File: rtl/smi_read_port.sv
module smi_read_port #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] top_i,
  input  logic [DATA_W-1:0] traps_i,
  output logic [DATA_W-1:0] rdata_o
);
  import smi_agg_pkg::*;

  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    unique case (addr_i)
      ADDR_TOP:    rdata_d = top_i;
      ADDR_MIRROR: rdata_d = traps_i;
      ADDR_CLEAR:  rdata_d = traps_i;
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o)); // R12
endmodule

// File: rtl/smi_status_agg.sv
module smi_status_agg
  import smi_agg_pkg::*;
#(
  parameter int unsigned NUM_GEN  = 4,
  parameter int unsigned NUM_FUNC = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en_i,
  input  logic [1:0]          addr_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                smi_o,
  input  logic                sw_smi_i,
  input  logic                a20_gate_wr_i,
  input  logic                a20_kbd_cmd_i,
  input  logic                a20_en_i,
  input  logic                lpc_pend_i,
  input  logic                acpi_pend_i,
  input  logic                audio_pend_i,
  input  logic                pme_pend_i,
  input  logic [NUM_GEN-1:0]  gen_trap_i,
  input  logic [NUM_GEN-1:0]  gen_trap_en_i,
  input  logic [NUM_FUNC-1:0] func_trap_i,
  input  logic [NUM_FUNC-1:0] func_trap_en_i,
  input  logic                udd3_trap_i,
  input  logic                udd3_en_i
);
  localparam int unsigned LEAF_N = 2;

  logic              clr_top, clr_traps;
  logic [LEAF_N-1:0] leaf_set, leaf_sts;
  logic [DATA_W-1:0] traps, top_view;

  assign clr_top   = rd_en_i && (addr_i == ADDR_TOP);
  assign clr_traps = rd_en_i && (addr_i == ADDR_CLEAR);

  // leaf index 1: software request, index 0: A20 toggle
  always_comb begin
    leaf_set[1] = sw_smi_i;
    leaf_set[0] = (a20_gate_wr_i | a20_kbd_cmd_i) & a20_en_i;
  end

  smi_rc_bits #(.N(LEAF_N)) u_leaf (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (leaf_set),
    .clr_i (clr_top),
    .sts_o (leaf_sts)
  );

  smi_trap_status #(
    .NUM_GEN  (NUM_GEN),
    .NUM_FUNC (NUM_FUNC),
    .DATA_W   (DATA_W)
  ) u_traps (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_hit_i  (gen_trap_i),
    .gen_en_i   (gen_trap_en_i),
    .func_hit_i (func_trap_i),
    .func_en_i  (func_trap_en_i),
    .udd_hit_i  (udd3_trap_i),
    .udd_en_i   (udd3_en_i),
    .clr_i      (clr_traps),
    .sts_o      (traps)
  );

  always_comb begin
    top_view            = '0;
    top_view[BIT_TRAPS] = |traps;
    top_view[BIT_SW]    = leaf_sts[1];
    top_view[BIT_A20]   = leaf_sts[0];
    top_view[BIT_LPC]   = lpc_pend_i;
    top_view[BIT_ACPI]  = acpi_pend_i;
    top_view[BIT_AUDIO] = audio_pend_i;
    top_view[BIT_PME]   = pme_pend_i;
  end

  assign smi_o = |top_view;

  smi_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .top_i   (top_view),
    .traps_i (traps),
    .rdata_o (rdata_o)
  );

  AST_LATCHED_RAISES_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    (|leaf_sts || |traps) |-> smi_o); // R11
  AST_MIRROR_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_MIRROR) |=> (($past(traps) & ~traps) == '0)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_TOP) |=> (rdata_o[6:4] == 3'b000 && rdata_o[15:10] == '0)); // R6
  AST_MIRROR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_MIRROR) |=> (rdata_o[15:6] == '0)); // R6
endmodule

// File: tb/smi_status_agg_tb.sv
module smi_status_agg_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic rd_en;
  logic [1:0] addr;
  logic [15:0] rdata;
  logic smi;
  logic sw, a20w, a20k, a20en, lpc, acpi, aud, pme;
  logic [3:0] gen, gen_en;
  logic [4:0] fn, fn_en;
  logic udd, udd_en;

  int nchk = 0;
  int nerr = 0;
  string cur_req = "R1";

  logic [15:0] m_rdata, m_trap;
  logic m_sw, m_a20, m_smi;

  always #(CLK_P/2) clk = ~clk;

  smi_status_agg u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .addr_i(addr), .rdata_o(rdata),
    .smi_o(smi), .sw_smi_i(sw), .a20_gate_wr_i(a20w), .a20_kbd_cmd_i(a20k),
    .a20_en_i(a20en), .lpc_pend_i(lpc), .acpi_pend_i(acpi), .audio_pend_i(aud),
    .pme_pend_i(pme), .gen_trap_i(gen), .gen_trap_en_i(gen_en),
    .func_trap_i(fn), .func_trap_en_i(fn_en), .udd3_trap_i(udd), .udd3_en_i(udd_en)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] top_val();
    logic [15:0] v;
    v = 16'h0;
    v[9] = (m_trap != 16'h0);
    v[8] = m_sw;
    v[7] = m_a20;
    v[3] = lpc; v[2] = acpi; v[1] = aud; v[0] = pme;
    return v;
  endfunction

  task automatic tick();
    logic [15:0] nt;
    @(posedge clk);
    if (rd_en) begin
      if (addr == 2'd0) m_rdata = top_val();
      else if (addr == 2'd3) m_rdata = 16'h0;
      else m_rdata = m_trap;
    end
    nt = 16'h0;
    nt[3:0] = gen & gen_en;
    nt[4] = udd & udd_en;
    nt[5] = |(fn & fn_en);
    m_trap = ((rd_en && addr == 2'd2) ? 16'h0 : m_trap) | nt;
    m_sw  = ((rd_en && addr == 2'd0) ? 1'b0 : m_sw) | sw;
    m_a20 = ((rd_en && addr == 2'd0) ? 1'b0 : m_a20) | ((a20w | a20k) & a20en);
    m_smi = (top_val() != 16'h0);
    @(negedge clk);
    chk({cur_req, " rdata"}, rdata, m_rdata);
    chk("R11 smi", {15'h0, smi}, {15'h0, m_smi});
  endtask

  task automatic clr_pulses();
    sw = 0; a20w = 0; a20k = 0; gen = '0; fn = '0; udd = 0; rd_en = 0;
  endtask

  task automatic rd(logic [1:0] a);
    rd_en = 1; addr = a;
    tick();
    clr_pulses();
  endtask

  initial begin
    #(CLK_P * 200000);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 0; addr = 0; a20en = 0; lpc = 0; acpi = 0; aud = 0; pme = 0;
    gen_en = '0; fn_en = '0; udd_en = 0;
    clr_pulses();
    m_rdata = 0; m_trap = 0; m_sw = 0; m_a20 = 0; m_smi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cur_req = "R1";
    chk("R1 rdata", rdata, 16'h0);
    chk("R1 smi", {15'h0, smi}, 16'h0);
    tick(); tick();
    // R2 software request, read to clear
    cur_req = "R2";
    sw = 1; tick(); clr_pulses();
    rd(2'd0);
    chk("R2 bit8 read", rdata, 16'h0100);
    rd(2'd0);
    chk("R2 bit8 cleared", rdata, 16'h0000);
    // R3 A20 toggle gated by enable
    cur_req = "R3";
    a20w = 1; tick(); clr_pulses();
    rd(2'd0);
    chk("R3 disabled", rdata, 16'h0);
    a20en = 1; a20k = 1; tick(); clr_pulses();
    rd(2'd0);
    chk("R3 kbd set", rdata, 16'h0080);
    a20w = 1; tick(); clr_pulses();
    rd(2'd0); rd(2'd0);
    chk("R3 cleared", rdata, 16'h0);
    // R4 summaries persist across reads
    cur_req = "R4";
    lpc = 1; acpi = 1; aud = 1; pme = 1;
    rd(2'd0); rd(2'd0);
    chk("R4 summary kept", rdata, 16'h000F);
    lpc = 0; aud = 0;
    rd(2'd0);
    chk("R4 follow", rdata, 16'h0005);
    acpi = 0; pme = 0; tick();
    // R8 trap capture with enables
    cur_req = "R8";
    gen = 4'b1111; gen_en = 4'b0101; fn = 5'b00100; fn_en = 5'b11011;
    udd = 1; udd_en = 0; tick(); clr_pulses();
    rd(2'd1);
    chk("R8 partial", rdata, 16'h0005);
    fn = 5'b01000; udd = 1; udd_en = 1; tick(); clr_pulses();
    // R7 mirror without side effect
    cur_req = "R7";
    rd(2'd1); rd(2'd1);
    chk("R7 mirror stable", rdata, 16'h0035);
    // R5 summary bit 9
    cur_req = "R5";
    rd(2'd0);
    chk("R5 bit9 set", rdata, 16'h0200);
    // R9 clearing read
    cur_req = "R9";
    rd(2'd2);
    chk("R9 returns", rdata, 16'h0035);
    rd(2'd1);
    chk("R9 cleared", rdata, 16'h0);
    cur_req = "R5";
    rd(2'd0);
    chk("R5 bit9 dropped", rdata, 16'h0);
    // R10 event beats clear
    cur_req = "R10";
    sw = 1; rd(2'd0);
    rd(2'd0);
    chk("R10 sw survives", rdata, 16'h0100);
    gen = 4'b0001; tick(); clr_pulses();
    gen = 4'b0100; rd(2'd2);
    rd(2'd1);
    chk("R10 trap survives", rdata, 16'h0004);
    rd(2'd2);
    // R6 reserved bits with everything set
    cur_req = "R6";
    lpc = 1; acpi = 1; aud = 1; pme = 1; sw = 1; a20w = 1; gen = 4'b0001;
    tick(); clr_pulses();
    rd(2'd0);
    chk("R6 top reserved", rdata & 16'hFC70, 16'h0);
    rd(2'd1);
    chk("R6 mirror reserved", rdata & 16'hFFC0, 16'h0);
    lpc = 0; acpi = 0; aud = 0; pme = 0;
    rd(2'd2);
    // R12 unused address and hold
    cur_req = "R12";
    sw = 1; tick(); clr_pulses();
    rd(2'd3);
    chk("R12 addr3 zero", rdata, 16'h0);
    rd(2'd0);
    tick(); tick();
    chk("R12 hold", rdata, 16'h0100);
    tick();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule